// File: doc/BRIEF.md
# Variable-Latency Speculative Segmented Adder

This block adds two WIDTH-bit operands without a full-length carry chain. The result word is split into SEG-bit output segments. Each segment above the lowest is produced by its own small adder, whose window covers that segment plus the SEG operand bits directly below it, with a carry-in of zero. The carry into each segment is therefore guessed from one neighbouring segment only. The critical path is one window adder, not the whole word.

A guess can be wrong only when every bit of the lower half of a window propagates (a XOR b all ones), because only then can a carry from further down pass through. The block raises a flag whenever any such window exists. When the flag is raised, the block presents the approximate sum for one cycle with the flag set and holds off new operands. In the next cycle it presents the exact sum, repaired by per-segment incrementors. Unflagged results are exact and finish in one cycle, so throughput drops only on flagged operations.

Top module: `aca_adder`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, valid_o, err_o and fix_o are 0, ready_o is 1 and sum_o is 0.
- R2: Operands are taken on a rising edge where valid_i and ready_o are both 1. After that edge valid_o is 1 and fix_o is 0. If no operands are taken and no repair is pending, valid_o is 0 after the edge.
- R3: The approximate sum takes bits [0, SEG) from the exact sum of those operand bits. For each segment s of 1 or more, it takes bits [s*SEG, s*SEG+SEG) from the upper part of the zero-carry-in sum of operand bits [(s-1)*SEG, s*SEG+SEG).
- R4: err_o is 1 in the cycle after taking operands exactly when some segment j from 0 to NSEG-2 has every bit of a_i XOR b_i set within [j*SEG, j*SEG+SEG).
- R5: Whenever the approximate sum differs from (a_i + b_i) mod 2^WIDTH, err_o is 1 while that sum is shown.
- R6: ready_o is 0 exactly in the cycles where err_o is 1. Operands offered with valid_i high in such a cycle are not taken and do not change any later result.
- R7: In the cycle after a cycle with err_o at 1, fix_o is 1, valid_o is 1, err_o is 0 and sum_o equals (a + b) mod 2^WIDTH of the flagged operands. This includes wrap-around at the top of the word.
- R8: A result shown with valid_o at 1 and err_o at 0 equals (a + b) mod 2^WIDTH of its operands.
- R9: With valid_i held high and no flagged operands, one new operand pair is taken and one result is shown in every cycle.
- R10: When SEG does not divide WIDTH, the top segment is narrower: WIDTH mod SEG bits wide. Its window is those bits plus the SEG bits below them, and R3 and R7 hold for it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on a_i and b_i are offered |
| ready_o | output | 1 | Block can take operands this cycle |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Approximate or repaired sum (registered) |
| valid_o | output | 1 | sum_o holds a result this cycle |
| err_o | output | 1 | sum_o is the approximate sum and may be wrong; repair follows |
| fix_o | output | 1 | sum_o is the repaired, exact sum |

## Verification
The bench runs with SEG=6 on a 16-bit word, so the top segment is 4 bits wide. It targets a carry that must ripple through a fully propagating window into that narrow segment, and the all-ones plus one case that wraps to zero. A design whose repair ignored the chain of propagating segments would show a wrong corrected sum there, and one with a misplaced window would fail the approximate-sum comparison. Operands held on valid_i during the flagged cycle with different values catch a design that takes input while repairing. A window that propagates with no carry beneath it checks that the flag is raised and that the repair leaves the already correct sum alone. Biased random operands of the form b = ~a ± small produce long propagate runs, so a detector that missed one window would let a wrong sum through with err_o low.

// File: rtl/aca_pkg.sv
package aca_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAN = 2'd1,
    PH_FLAG  = 2'd2,
    PH_FIX   = 2'd3
  } phase_e;

  function automatic int unsigned seg_count(input int unsigned w, input int unsigned k);
    return (w + k - 1) / k;
  endfunction

  function automatic int unsigned seg_hi(input int unsigned w, input int unsigned k,
                                         input int unsigned s);
    return ((s + 1) * k > w) ? w : (s + 1) * k;
  endfunction
endpackage

// File: rtl/aca_subadder.sv
// One window adder: SEG guess bits below, OW result bits above, carry-in zero.
module aca_subadder #(
  parameter int unsigned SEG = 4,
  parameter int unsigned OW  = 4
) (
  input  logic [SEG+OW-1:0] win_a_i,
  input  logic [SEG+OW-1:0] win_b_i,
  output logic [OW-1:0]     seg_o
);
  assign seg_o = OW'((win_a_i + win_b_i) >> SEG);
endmodule

// File: rtl/aca_detect.sv
// Group propagate (AND tree) and generate for every segment that feeds a guess.
module aca_detect #(
  parameter int unsigned SEG   = 4,
  parameter int unsigned NLOW  = 3,
  localparam int unsigned LW   = NLOW * SEG
) (
  input  logic [LW-1:0]   a_i,
  input  logic [LW-1:0]   b_i,
  output logic [NLOW-1:0] p_o,
  output logic [NLOW-1:0] g_o
);
  for (genvar j = 0; j < NLOW; j++) begin : g_grp
    logic [SEG-1:0] a_s, b_s;
    assign a_s    = a_i[j*SEG +: SEG];
    assign b_s    = b_i[j*SEG +: SEG];
    assign p_o[j] = &(a_s ^ b_s);
    assign g_o[j] = 1'(({1'b0, a_s} + {1'b0, b_s}) >> SEG);
  end
endmodule

// File: rtl/aca_fix.sv
// Repair: true carries ripple across segments only; each segment gets +1 where the guess missed.
module aca_fix #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SEG   = 4,
  localparam int unsigned NSEG = aca_pkg::seg_count(WIDTH, SEG)
) (
  input  logic [WIDTH-1:0]  sum_i,
  input  logic [NSEG-2:0]   p_i,
  input  logic [NSEG-2:0]   g_i,
  output logic [WIDTH-1:0]  sum_o
);
  logic [NSEG-1:0] c;

  assign c[0]            = 1'b0;
  assign sum_o[SEG-1:0]  = sum_i[SEG-1:0];

  for (genvar s = 1; s < NSEG; s++) begin : g_inc
    localparam int unsigned LO = s * SEG;
    localparam int unsigned HI = aca_pkg::seg_hi(WIDTH, SEG, s);
    assign c[s]            = g_i[s-1] | (p_i[s-1] & c[s-1]);
    assign sum_o[HI-1:LO]  = sum_i[HI-1:LO] + (HI-LO)'(c[s] ^ g_i[s-1]);
  end
endmodule

// File: rtl/aca_adder.sv
module aca_adder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SEG   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             fix_o
);
  import aca_pkg::*;

  localparam int unsigned NSEG = seg_count(WIDTH, SEG);
  localparam int unsigned NLOW = NSEG - 1;
  localparam int unsigned LW   = NLOW * SEG;

  logic [WIDTH-1:0] approx_w, fixed_w, sum_q;
  logic [NLOW-1:0]  p_w, g_w, p_q, g_q;
  phase_e           phase_q;
  logic             take;

  // lowest segment: exact, zero guess bits below it
  aca_subadder #(.SEG(SEG), .OW(SEG)) u_seg0 (
    .win_a_i ({a_i[SEG-1:0], {SEG{1'b0}}}),
    .win_b_i ({b_i[SEG-1:0], {SEG{1'b0}}}),
    .seg_o   (approx_w[SEG-1:0])
  );

  for (genvar s = 1; s < NSEG; s++) begin : g_seg
    localparam int unsigned LO = s * SEG;
    localparam int unsigned HI = seg_hi(WIDTH, SEG, s);
    aca_subadder #(.SEG(SEG), .OW(HI-LO)) u_sub (
      .win_a_i (a_i[HI-1:LO-SEG]),
      .win_b_i (b_i[HI-1:LO-SEG]),
      .seg_o   (approx_w[HI-1:LO])
    );
  end

  aca_detect #(.SEG(SEG), .NLOW(NLOW)) u_det (
    .a_i (a_i[LW-1:0]),
    .b_i (b_i[LW-1:0]),
    .p_o (p_w),
    .g_o (g_w)
  );

  aca_fix #(.WIDTH(WIDTH), .SEG(SEG)) u_fix (
    .sum_i (sum_q),
    .p_i   (p_q),
    .g_i   (g_q),
    .sum_o (fixed_w)
  );

  assign ready_o = (phase_q != PH_FLAG);
  assign take    = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sum_q   <= '0;
      p_q     <= '0;
      g_q     <= '0;
    end else if (phase_q == PH_FLAG) begin
      phase_q <= PH_FIX;
      sum_q   <= fixed_w;
    end else if (take) begin
      phase_q <= (|p_w) ? PH_FLAG : PH_CLEAN;
      sum_q   <= approx_w;
      p_q     <= p_w;
      g_q     <= g_w;
    end else begin
      phase_q <= PH_IDLE;
    end
  end

  assign sum_o   = sum_q;
  assign valid_o = (phase_q != PH_IDLE);
  assign err_o   = (phase_q == PH_FLAG);
  assign fix_o   = (phase_q == PH_FIX);
endmodule

// File: rtl/aca_adder_chk.sv
module aca_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_o,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             valid_o,
  input logic             err_o,
  input logic             fix_o
);
  logic [WIDTH-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ref_q <= '0;
    else if (valid_i && ready_o) ref_q <= a_i + b_i;
  end

  // R2
  take_shows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (valid_o && !fix_o));

  // R6
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ready_o);

  // R7
  fix_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (fix_o && valid_o));

  // R7
  fix_after_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |-> $past(err_o));

  // R8
  exact_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (sum_o == ref_q));

  // R2
  flags_need_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || fix_o) |-> (valid_o && $onehot0({err_o, fix_o})));
endmodule

bind aca_adder aca_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .a_i     (a_i),
  .b_i     (b_i),
  .sum_o   (sum_o),
  .valid_o (valid_o),
  .err_o   (err_o),
  .fix_o   (fix_o)
);

// File: tb/aca_adder_test.sv
module aca_adder_test;
  localparam int W = 16;
  localparam int K = 6;   // R10: 16 = 6 + 6 + 4, narrow top segment
  localparam int NS = (W + K - 1) / K;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         ready_o, valid_o, err_o, fix_o;
  logic [W-1:0] sum_o;

  int vectors = 0;
  int miscompares = 0;

  // model state: 0 idle, 1 clean, 2 flagged, 3 repaired
  int           mph = 0;
  logic [W-1:0] msum = '0, mexact = '0;

  always #10 clk_i = ~clk_i;

  aca_adder #(.WIDTH(W), .SEG(K)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .valid_o(valid_o), .err_o(err_o), .fix_o(fix_o)
  );

  function automatic logic [W-1:0] ref_approx(input logic [W-1:0] a, input logic [W-1:0] b);
    longint r = 0;
    for (int s = 0; s < NS; s++) begin
      int lo  = s * K;
      int wlo = (s == 0) ? 0 : lo - K;
      int hi  = (lo + K > W) ? W : lo + K;
      longint wa = (longint'(a) >> wlo) & ((64'd1 << (hi - wlo)) - 1);
      longint wb = (longint'(b) >> wlo) & ((64'd1 << (hi - wlo)) - 1);
      longint piece = ((wa + wb) >> (lo - wlo)) & ((64'd1 << (hi - lo)) - 1);
      r = r | (piece << lo);
    end
    return W'(r);
  endfunction

  function automatic bit ref_flag(input logic [W-1:0] a, input logic [W-1:0] b);
    bit f = 0;
    for (int j = 0; j < NS - 1; j++)
      if (((int'(a ^ b) >> (j * K)) & ((1 << K) - 1)) == ((1 << K) - 1)) f = 1;
    return f;
  endfunction

  task automatic report(input string req, input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic check_now();
    vectors++;
    if (valid_o !== (mph != 0)) report("R2", "valid_o", int'(valid_o), int'(mph != 0));
    if (err_o   !== (mph == 2)) report("R4", "err_o",   int'(err_o),   int'(mph == 2));
    if (fix_o   !== (mph == 3)) report("R7", "fix_o",   int'(fix_o),   int'(mph == 3));
    if (ready_o !== (mph != 2)) report("R6", "ready_o", int'(ready_o), int'(mph != 2));
    if (mph == 1 || mph == 2) begin
      if (sum_o !== msum) report("R3", "approx sum", int'(sum_o), int'(msum));
    end
    if (mph == 3 && sum_o !== mexact) report("R7", "repaired sum", int'(sum_o), int'(mexact));
    // R5 and R8: an unflagged result must already be exact
    if (valid_o === 1'b1 && err_o === 1'b0 && fix_o === 1'b0 && sum_o !== mexact)
      report("R5", "unflagged wrong sum", int'(sum_o), int'(mexact));
  endtask

  // called at a falling edge: drive, advance model, wait one cycle, check
  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b);
    valid_i = v;
    a_i     = a;
    b_i     = b;
    if (mph == 2) begin
      mph  = 3;
      msum = mexact;
    end else if (v) begin
      mexact = a + b;
      msum   = ref_approx(a, b);
      mph    = ref_flag(a, b) ? 2 : 1;
    end else begin
      mph = 0;
    end
    @(negedge clk_i);
    check_now();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    report("WD", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: during reset and right after release
    repeat (3) @(negedge clk_i);
    check_now();
    if (sum_o !== '0) report("R1", "sum_o in reset", int'(sum_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_now();
    if (sum_o !== '0) report("R1", "sum_o after reset", int'(sum_o), 0);

    // R2 R3: plain, no propagate window
    step(1, 16'h0001, 16'h0002);
    // R4 R5: carry passes a full propagate window into the narrow top segment (R10)
    step(1, 16'h0FFF, 16'h0001);
    // R6: different operands offered while flagged, not taken
    step(1, 16'h1234, 16'h1111);
    // R7: repaired 0x1000 shown now; same operands now taken
    step(1, 16'h1234, 16'h1111);
    // R4: window propagates, no carry below; flag raised, repair keeps the value
    step(1, 16'h003F, 16'h0000);
    step(0, 16'h0000, 16'h0000);
    // R7 R10: wrap-around at the top of the word
    step(1, 16'hFFFF, 16'h0001);
    step(0, 16'hAAAA, 16'h5555);
    step(0, 16'h0000, 16'h0000);
    // R9: back-to-back clean operations
    step(1, 16'h0102, 16'h0304);
    step(1, 16'h1000, 16'h2000);
    step(1, 16'h7F00, 16'h0100);
    step(1, 16'h0040, 16'h0080);
    step(0, 16'h0000, 16'h0000);
    // R3 R5 R8: biased random with long propagate runs
    for (int i = 0; i < 6000; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      case ($urandom % 3)
        0: rb = W'($urandom);
        1: rb = ~ra ^ W'(1 << ($urandom % W));
        default: rb = ~ra + W'($urandom % 3);
      endcase
      step(($urandom % 5) != 0, ra, rb);
    end
    step(0, 16'h0000, 16'h0000);
    step(0, 16'h0000, 16'h0000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule